// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block produces the column address of every beat of a read or write burst for one SDRAM bank. A column command (a start pulse with its column, a read/write flag and an auto-precharge flag) loads the sequencer. It then emits one column per clock with a valid strobe until the burst runs out or is cut short. A one-clock done pulse marks the end of each burst.

The burst shape comes from a mode word that is sampled when each command is accepted. The mode word sets the length (1, 2, 4, 8 or an endless full page) and the counting order (sequential or interleaved). It can also force every write burst down to one beat. A running burst can be ended early by a new column command, by a same-bank precharge or by a burst stop. After a read stop, the block keeps supplying columns for as many beats as the CAS latency requires. Bursts that carry auto-precharge cannot be cut. Any attempt to cut them is dropped and reported on a flag.

Top module: `burst_col_seq`

## Requirements
- R1: While reset is held and after it is released with no command, colValid, burstDone and intBlocked are all low.
- R2: modeWord[2:0] sets the length. 000, 001, 010 and 011 give 1, 2, 4 and 8 beats, 111 gives full page, and 100 to 110 give 1 beat. colValid rises in the cycle after an accepted command and stays high for exactly that many cycles.
- R3: With modeWord[3]=0, beat k of a burst of length L in {1,2,4,8} carries the start column with its low log2(L) bits replaced by (start low bits + k) mod L. The higher bits keep their start value.
- R4: With modeWord[3]=1 and L of 4 or 8, the low bits of beat k are the start low bits XOR k. For L of 1 or 2 the sequence equals the sequential one.
- R5: With modeWord[9]=1, every write burst is one beat long whatever the length code. Reads keep the programmed length.
- R6: A full-page burst steps the whole 8-bit column by +1 each beat, wraps from 255 to 0 and never ends by itself. It counts sequentially even when modeWord[3]=1.
- R7: burstDone is high for one cycle after the last valid beat of a burst. It is also high in the cycle after any early end, and in that cycle colValid shows the new burst if one was started.
- R8: An accepted command during a running, unlocked burst ends that burst. The next cycle carries beat 0 of the new burst. Commands may arrive on every clock.
- R9: preCmd during a running, unlocked burst ends it with no further valid beat. A cycle with preCmd high starts no burst.
- R10: stopCmd during an unlocked write burst ends it at once. During a read burst, it allows one more beat when modeWord[6:4] is not 011 and two more beats when it is 011, followed by the end. A further stop while those beats run has no effect.
- R11: A finite burst started with autoPre high ignores stopCmd, preCmd and cmdStart until its natural end. intBlocked is high in the cycle after each such ignored cycle. autoPre has no such effect on full-page bursts.
- R12: stopCmd and preCmd while no burst runs have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| modeWord | input | 10 | Mode settings: length [2:0], order [3], latency [6:4], write single beat [9] |
| cmdStart | input | 1 | Column command for this bank |
| startCol | input | 8 | Start column of the command |
| startWrite | input | 1 | 1 for write, 0 for read |
| autoPre | input | 1 | Command carries auto-precharge |
| stopCmd | input | 1 | Burst stop |
| preCmd | input | 1 | Precharge to this bank |
| colAddr | output | 8 | Column of the current beat |
| colValid | output | 1 | colAddr carries a burst beat |
| burstDone | output | 1 | A burst ended at the previous edge |
| intBlocked | output | 1 | A cut was refused at the previous edge |

## Verification
The bench builds the block with its defaults: an 8-bit column and a 10-bit mode word. Because the page is only 256 columns, a full-page burst can be left running past its wrap point and still be stopped within a few hundred cycles. With the 3-bit in-burst offset of length 8, both the XOR order and the sequential wrap can be checked at unaligned start columns. Both latency codes are applied at stop time, so the one-beat and two-beat read tails are each compared against a behavioural model.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  // bit positions inside the mode word
  localparam int LEN_LSB   = 0;
  localparam int ORDER_BIT = 3;
  localparam int LAT_LSB   = 4;
  localparam int WRS_BIT   = 9;
  localparam logic [2:0] LAT_THREE = 3'd3;
  localparam logic [2:0] LEN_FULL  = 3'b111;

  typedef struct packed {
    logic load;
    logic step;
  } seqStrobe_t;
endpackage

// File: rtl/bcs_ctrl.sv
module bcs_ctrl
  import bcs_pkg::*;
#(
  parameter int COL_W  = 8,
  parameter int MODE_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [MODE_W-1:0] modeWord,
  input  logic              cmdStart,
  input  logic              startWrite,
  input  logic              autoPre,
  input  logic              stopCmd,
  input  logic              preCmd,
  input  logic              lastBeat,
  output seqStrobe_t        strb,
  output logic [COL_W-1:0]  cfgMask,
  output logic              cfgIlv,
  output logic              cfgFull,
  output logic              colValid,
  output logic              burstDone,
  output logic              intBlocked
);
  logic       activeQ, apLockQ, isWriteQ, doneQ, blockedQ;
  logic [1:0] drainLeftQ;
  logic       cutOk, startOk, drainEnd, stopEnd, stopDrain, endNow;
  logic [2:0] lenCode;
  logic       latThree;

  assign lenCode  = modeWord[LEN_LSB +: 3];
  assign latThree = (modeWord[LAT_LSB +: 3] == LAT_THREE);

  // length and order decode for the command being accepted
  always_comb begin
    cfgFull = (lenCode == LEN_FULL);
    unique case (lenCode)
      3'b001:   cfgMask = COL_W'(1);
      3'b010:   cfgMask = COL_W'(3);
      3'b011:   cfgMask = COL_W'(7);
      3'b111:   cfgMask = '1;
      default:  cfgMask = '0;
    endcase
    if (startWrite && modeWord[WRS_BIT]) begin
      cfgMask = '0;
      cfgFull = 1'b0;
    end
    cfgIlv = modeWord[ORDER_BIT] && !cfgFull;
  end

  assign cutOk     = activeQ && !apLockQ;
  assign startOk   = cmdStart && !preCmd && (!activeQ || !apLockQ);
  assign drainEnd  = cutOk && (drainLeftQ == 2'd1);
  assign stopEnd   = cutOk && stopCmd && (drainLeftQ == 2'd0) && isWriteQ;
  assign stopDrain = cutOk && stopCmd && (drainLeftQ == 2'd0) && !isWriteQ
                     && !cmdStart && !preCmd;
  assign endNow    = activeQ && (lastBeat || (cutOk && (preCmd || cmdStart))
                                 || drainEnd || stopEnd);

  assign strb.load = startOk;
  assign strb.step = activeQ && !startOk && !endNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeQ    <= 1'b0;
      apLockQ    <= 1'b0;
      isWriteQ   <= 1'b0;
      drainLeftQ <= 2'd0;
      doneQ      <= 1'b0;
      blockedQ   <= 1'b0;
    end else begin
      doneQ    <= endNow;
      blockedQ <= activeQ && apLockQ && (cmdStart || preCmd || stopCmd);
      if (startOk) begin
        activeQ    <= 1'b1;
        apLockQ    <= autoPre && !cfgFull;
        isWriteQ   <= startWrite;
        drainLeftQ <= 2'd0;
      end else if (endNow) begin
        activeQ    <= 1'b0;
        apLockQ    <= 1'b0;
        drainLeftQ <= 2'd0;
      end else if (stopDrain) begin
        drainLeftQ <= latThree ? 2'd2 : 2'd1;
      end else if (drainLeftQ != 2'd0) begin
        drainLeftQ <= drainLeftQ - 2'd1;
      end
    end
  end

  assign colValid   = activeQ;
  assign burstDone  = doneQ;
  assign intBlocked = blockedQ;

  // R7: a done pulse with no beat showing follows a beat
  assert_done_after_beat_R7: assert property (@(posedge clk) disable iff (!rstN)
    (burstDone && !colValid) |-> $past(colValid));

  // R11: a locked finite burst only stops at its last beat
  assert_lock_holds_R11: assert property (@(posedge clk) disable iff (!rstN)
    (activeQ && apLockQ && !lastBeat) |=> activeQ);

  // R11: a refusal is reported only while a burst was running
  assert_block_flag_R11: assert property (@(posedge clk) disable iff (!rstN)
    intBlocked |-> $past(colValid));

  // R5: single-beat writes end at their first beat
  assert_write_single_R5: assert property (@(posedge clk) disable iff (!rstN)
    (startOk && startWrite && modeWord[WRS_BIT]) |=> lastBeat);

  // R10: a write stop ends the burst at once
  assert_write_stop_R10: assert property (@(posedge clk) disable iff (!rstN)
    (cutOk && isWriteQ && stopCmd && !cmdStart) |=> !colValid);
endmodule

// File: rtl/bcs_datapath.sv
module bcs_datapath
  import bcs_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strb,
  input  logic [COL_W-1:0] startCol,
  input  logic [COL_W-1:0] cfgMask,
  input  logic             cfgIlv,
  input  logic             cfgFull,
  output logic [COL_W-1:0] colAddr,
  output logic             lastBeat
);
  logic [COL_W-1:0] baseQ, cntQ, maskQ, offs;
  logic             ilvQ, fullQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseQ <= '0;
      cntQ  <= '0;
      maskQ <= '0;
      ilvQ  <= 1'b0;
      fullQ <= 1'b0;
    end else if (strb.load) begin
      baseQ <= startCol;
      cntQ  <= '0;
      maskQ <= cfgMask;
      ilvQ  <= cfgIlv;
      fullQ <= cfgFull;
    end else if (strb.step) begin
      cntQ <= cntQ + 1'b1;
    end
  end

  assign offs     = ilvQ ? (baseQ ^ cntQ) : (baseQ + cntQ);
  assign colAddr  = (baseQ & ~maskQ) | (offs & maskQ);
  assign lastBeat = !fullQ && (cntQ == maskQ);

  // R3: bits above the burst block never move within a burst
  assert_block_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.step |=> ((colAddr & ~maskQ) == ($past(colAddr) & ~$past(maskQ))));

  // R6: full-page beats step by one with wrap
  assert_page_step_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.step && fullQ) |=> (colAddr == COL_W'($past(colAddr) + 1'b1)));
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import bcs_pkg::*;
#(
  parameter int COL_W  = 8,
  parameter int MODE_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [MODE_W-1:0] modeWord,
  input  logic              cmdStart,
  input  logic [COL_W-1:0]  startCol,
  input  logic              startWrite,
  input  logic              autoPre,
  input  logic              stopCmd,
  input  logic              preCmd,
  output logic [COL_W-1:0]  colAddr,
  output logic              colValid,
  output logic              burstDone,
  output logic              intBlocked
);
  seqStrobe_t       strb;
  logic [COL_W-1:0] cfgMask;
  logic             cfgIlv, cfgFull, lastBeat;

  bcs_ctrl #(.COL_W(COL_W), .MODE_W(MODE_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .modeWord(modeWord), .cmdStart(cmdStart),
    .startWrite(startWrite), .autoPre(autoPre), .stopCmd(stopCmd),
    .preCmd(preCmd), .lastBeat(lastBeat), .strb(strb), .cfgMask(cfgMask),
    .cfgIlv(cfgIlv), .cfgFull(cfgFull), .colValid(colValid),
    .burstDone(burstDone), .intBlocked(intBlocked)
  );

  bcs_datapath #(.COL_W(COL_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .startCol(startCol),
    .cfgMask(cfgMask), .cfgIlv(cfgIlv), .cfgFull(cfgFull),
    .colAddr(colAddr), .lastBeat(lastBeat)
  );

  logic unusedModeBits;
  assign unusedModeBits = ^modeWord[8:7];
endmodule

// File: tb/burst_col_seq_tb.sv
module burst_col_seq_tb;
  localparam int PAGE = 256;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [9:0] modeWord = '0;
  logic       cmdStart = 0, startWrite = 0, autoPre = 0, stopCmd = 0, preCmd = 0;
  logic [7:0] startCol = '0;
  logic [7:0] colAddr;
  logic       colValid, burstDone, intBlocked;

  int    checks = 0, failures = 0;
  bit    run = 0;
  string curReq = "R1";

  // reference model state
  int mAct = 0, mBase = 0, mCnt = 0, mLen = 1, mIlv = 0, mFull = 0;
  int mAp = 0, mWr = 0, mDrain = 0, eDone = 0, eBlk = 0;
  int last, ending, startNow, newDrain, code;

  burst_col_seq u_dut (
    .clk(clk), .rstN(rstN), .modeWord(modeWord), .cmdStart(cmdStart),
    .startCol(startCol), .startWrite(startWrite), .autoPre(autoPre),
    .stopCmd(stopCmd), .preCmd(preCmd), .colAddr(colAddr),
    .colValid(colValid), .burstDone(burstDone), .intBlocked(intBlocked)
  );

  always #5 clk = ~clk;

  function automatic int expAddr();
    int lo, off;
    if (mFull != 0) return (mBase + mCnt) % PAGE;
    lo = mBase % mLen;
    if (mIlv != 0 && mLen >= 4) off = lo ^ mCnt;
    else off = (lo + mCnt) % mLen;
    return (mBase - lo) + off;
  endfunction

  function automatic logic [9:0] mw(int lenc, int ilv, int lat, int wrs);
    logic [9:0] v = '0;
    v[2:0] = lenc[2:0];
    v[3]   = ilv[0];
    v[6:4] = lat[2:0];
    v[9]   = wrs[0];
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mAct = 0; mCnt = 0; mAp = 0; mDrain = 0; eDone = 0; eBlk = 0;
    end else begin
      eBlk = (mAct != 0 && mAp != 0 && (cmdStart || stopCmd || preCmd)) ? 1 : 0;
      last = (mAct != 0 && mFull == 0 && mCnt == mLen - 1) ? 1 : 0;
      ending = 0;
      newDrain = mDrain;
      if (mAct != 0) begin
        if (last != 0) ending = 1;
        else if (mAp == 0) begin
          if (preCmd || cmdStart) ending = 1;
          else if (mDrain == 1) ending = 1;
          else if (mDrain == 2) newDrain = 1;
          else if (stopCmd) begin
            if (mWr != 0) ending = 1;
            else newDrain = (modeWord[6:4] == 3) ? 2 : 1;
          end
        end
      end
      startNow = (cmdStart && !preCmd && (mAct == 0 || mAp == 0)) ? 1 : 0;
      eDone = ending;
      if (startNow != 0) begin
        code = modeWord[2:0];
        case (code)
          0: mLen = 1;
          1: mLen = 2;
          2: mLen = 4;
          3: mLen = 8;
          7: mLen = PAGE;
          default: mLen = 1;
        endcase
        mFull = (code == 7) ? 1 : 0;
        if (startWrite && modeWord[9]) begin mLen = 1; mFull = 0; end
        mIlv = modeWord[3];
        mAp = (autoPre && mFull == 0) ? 1 : 0;
        mWr = startWrite;
        mBase = startCol;
        mCnt = 0; mAct = 1; mDrain = 0;
      end else if (ending != 0) begin
        mAct = 0; mDrain = 0; mAp = 0;
      end else if (mAct != 0) begin
        mCnt = (mCnt + 1) % PAGE;
        mDrain = newDrain;
      end
    end
  end

  always @(negedge clk) begin
    if (rstN && run) begin
      chk(colValid === (mAct != 0), {curReq, " valid"}, colValid, mAct);
      chk(burstDone === (eDone != 0), "R7 done", burstDone, eDone);
      chk(intBlocked === (eBlk != 0), "R11 blocked", intBlocked, eBlk);
      if (mAct != 0) chk(colAddr == expAddr(), {curReq, " column"}, colAddr, expAddr());
    end
  end

  task automatic drv(input bit s, input int col, input bit wr, input bit ap,
                     input bit stp, input bit pre);
    cmdStart = s; startCol = col[7:0]; startWrite = wr; autoPre = ap;
    stopCmd = stp; preCmd = pre;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drv(0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(colValid === 1'b0, "R1 valid", colValid, 0);
    chk(burstDone === 1'b0, "R1 done", burstDone, 0);
    chk(intBlocked === 1'b0, "R1 blocked", intBlocked, 0);
    rstN = 1'b1;
    run = 1;
    idle(3);

    curReq = "R2";
    for (int c = 0; c < 5; c++) begin
      modeWord = mw(c, 0, 2, 0);
      drv(1, 8'h35, 0, 0, 0, 0);
      idle(10);
    end

    curReq = "R3";
    modeWord = mw(3, 0, 2, 0); drv(1, 8'h6B, 0, 0, 0, 0); idle(10);
    modeWord = mw(2, 0, 2, 0); drv(1, 8'h12, 1, 0, 0, 0); idle(6);

    curReq = "R4";
    modeWord = mw(2, 1, 2, 0); drv(1, 8'h35, 0, 0, 0, 0); idle(6);
    modeWord = mw(3, 1, 2, 0); drv(1, 8'h2E, 0, 0, 0, 0); idle(10);
    modeWord = mw(1, 1, 2, 0); drv(1, 8'h33, 0, 0, 0, 0); idle(4);
    modeWord = mw(0, 1, 2, 0); drv(1, 8'h47, 0, 0, 0, 0); idle(3);

    curReq = "R5";
    modeWord = mw(3, 0, 2, 1); drv(1, 8'h44, 1, 0, 0, 0); idle(4);
    drv(1, 8'h44, 0, 0, 0, 0); idle(10);
    modeWord = mw(7, 0, 2, 1); drv(1, 8'h90, 1, 0, 0, 0); idle(4);

    curReq = "R6";
    modeWord = mw(7, 1, 2, 0); drv(1, 8'hFC, 0, 1, 0, 0); idle(300);
    curReq = "R10";
    drv(0, 0, 0, 0, 1, 0); idle(5);
    modeWord = mw(7, 0, 3, 0); drv(1, 8'h10, 0, 0, 0, 0); idle(4);
    drv(0, 0, 0, 0, 1, 0); drv(0, 0, 0, 0, 1, 0); idle(5);
    drv(1, 8'h20, 1, 0, 0, 0); idle(3); drv(0, 0, 0, 0, 1, 0); idle(4);
    modeWord = mw(3, 0, 2, 0); drv(1, 8'h58, 0, 0, 0, 0); idle(2);
    drv(0, 0, 0, 0, 1, 0); idle(5);
    modeWord = mw(3, 0, 3, 0); drv(1, 8'h5E, 0, 0, 0, 0); idle(5);
    drv(0, 0, 0, 0, 1, 0); idle(5);

    curReq = "R8";
    modeWord = mw(3, 0, 2, 0); drv(1, 8'h01, 0, 0, 0, 0);
    for (int i = 0; i < 6; i++) drv(1, 8'h30 + 9 * i, i % 2, 0, 0, 0);
    idle(2); drv(1, 8'hA3, 0, 0, 0, 0); drv(1, 8'hC5, 0, 0, 1, 0); idle(10);

    curReq = "R9";
    drv(1, 8'h70, 0, 0, 0, 0); idle(2); drv(0, 0, 0, 0, 0, 1); idle(4);
    drv(1, 8'h70, 1, 0, 0, 0); idle(1); drv(1, 8'h80, 0, 0, 0, 1); idle(4);
    drv(1, 8'h81, 0, 0, 0, 1); idle(4);

    curReq = "R11";
    modeWord = mw(2, 0, 3, 0); drv(1, 8'h3A, 0, 1, 0, 0);
    drv(0, 0, 0, 0, 1, 0); drv(0, 0, 0, 0, 0, 1); drv(1, 8'h10, 0, 0, 0, 0); idle(4);
    modeWord = mw(3, 0, 2, 0); drv(1, 8'h07, 1, 1, 0, 0); idle(7);
    drv(1, 8'h00, 0, 0, 0, 0); idle(10);
    modeWord = mw(7, 0, 2, 0); drv(1, 8'hE0, 1, 1, 0, 0); idle(3);
    drv(0, 0, 0, 0, 0, 1); idle(3);

    curReq = "R12";
    drv(0, 0, 0, 0, 1, 0); drv(0, 0, 0, 0, 0, 1); idle(2);
    drv(0, 0, 0, 0, 1, 1); idle(2);

    run = 0;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule